// File: doc/BRIEF.md
# Disk Controller Soft-Switch Decoder

This block turns accesses to a sixteen-location I/O window into the control state of a floppy disk controller. Each access carries only the low address nibble and a valid strobe. The low eight locations set or clear the four head-stepper phase lines one at a time. The upper eight locations control the spindle motor, choose between two drives, set the two sequencer mode latches and start or stop a write. The stepper arithmetic and the read/write sequencer sit outside this block. The block sees the sequencer's shift register only as an input, and it gives the sequencer a one-cycle clear pulse plus write begin and write end strobes.

A motor-off access does not stop the motor at once. It arms a countdown of `CLK_HZ` clock cycles, which is one second at the design clock. When the countdown runs out, the motor stops. A motor-on access arms nothing: it turns the motor on at once and cancels any countdown still pending. The motor reaches only the selected drive, so changing drives moves the current motor state from the old drive to the new one. Read data comes back in the same cycle as the address. An even address returns the shift register and an odd address returns all ones.

Top module: `disk_switch_decoder`

## Requirements
- R1: After reset all four phases are off, the motor is off on both drives, drive 0 is selected, mode latch A (`q6`) is 1, mode latch B (`q7`) is 0, and all pulse outputs are low.
- R2: A valid access to an address from 0x0 to 0x7 writes bit 0 of the address into phase line `phase[addr[2:1]]` and leaves the other lines unchanged. The new value shows from the cycle after the access.
- R3: A valid access to 0x8 raises `sr_clear` for exactly the one cycle after the access and arms a countdown. If nothing intervenes, `motor_en` falls exactly `CLK_HZ` clock edges after the access edge.
- R4: A valid access to 0x9 sets `motor_en` from the next cycle and cancels any pending countdown.
- R5: A new 0x8 access while a countdown is pending restarts the countdown from its full length.
- R6: Addresses 0xA and 0xB select drive 0 and drive 1. `drive_motor[i]` equals `motor_en` when drive i is selected and is 0 otherwise, so the motor state follows the selection.
- R7: Selecting the drive that is already active changes no output.
- R8: Addresses 0xC and 0xD clear and set `q6`.
- R9: Addresses 0xE and 0xF clear and set `q7`. `write_end` or `write_begin` pulses for one cycle only when `q7` actually goes from 1 to 0 or from 0 to 1.
- R10: `rd_data` is combinational from the current address: `shift_in` when `acc_addr[0]` is 0, and 0xFF when it is 1.
- R11: While `acc_valid` is low, no latch, phase, selection or motor command changes, and no pulse is raised. A countdown that is already running still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_addr | input | 4 | Low address nibble of the access |
| shift_in | input | 8 | Sequencer shift register value |
| rd_data | output | 8 | Read data for the current address |
| phase | output | 4 | Stepper phase lines |
| motor_en | output | 1 | Controller motor command |
| drive_motor | output | 2 | Motor enable per drive |
| drive_sel | output | 1 | Selected drive |
| q6 | output | 1 | Sequencer mode latch A |
| q7 | output | 1 | Sequencer mode latch B (write mode) |
| sr_clear | output | 1 | One-cycle shift register clear |
| write_begin | output | 1 | One-cycle strobe when write mode starts |
| write_end | output | 1 | One-cycle strobe when write mode stops |

## Verification
The properties assume that `acc_addr` holds a defined nibble whenever `acc_valid` is high. They also assume at most one access per cycle, and that no access arrives during the two cycles in which the internal reset is still being released. The stimulus changes inputs only on falling edges. After reset it waits several idle cycles before the first access, and it always drives a known address, even when the strobe is low. The countdown tests use a short `CLK_HZ`, so the expiry edge and the restart and cancel cases all fit in a short run.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  localparam int NUM_PHASES = 4;
  localparam int NUM_DRIVES = 2;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;

  // Upper-half command codes (address bits [2:1] when address bit 3 is set)
  typedef enum logic [1:0] {
    GRP_MOTOR = 2'd0,
    GRP_DRIVE = 2'd1,
    GRP_LATA  = 2'd2,
    GRP_LATB  = 2'd3
  } cmd_grp_e;

  typedef struct packed {
    logic       phase_wr;
    logic [1:0] phase_idx;
    logic       bit_val;
    logic       motor_off;
    logic       motor_on;
    logic       sel_wr;
    logic       lat_a_wr;
    logic       lat_b_wr;
  } dsd_cmd_t;

endpackage

// File: rtl/dsd_decode.sv
module dsd_decode
  import dsd_pkg::*;
(
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] shift_in,
  output dsd_cmd_t          cmd,
  output logic [DATA_W-1:0] rd_data
);

  cmd_grp_e grp;

  always_comb begin
    grp           = cmd_grp_e'(acc_addr[2:1]);
    cmd           = '0;
    cmd.bit_val   = acc_addr[0];
    cmd.phase_idx = acc_addr[2:1];
    if (acc_valid) begin
      if (!acc_addr[3]) begin
        cmd.phase_wr = 1'b1;
      end else begin
        unique case (grp)
          GRP_MOTOR: begin
            cmd.motor_on  = acc_addr[0];
            cmd.motor_off = ~acc_addr[0];
          end
          GRP_DRIVE: cmd.sel_wr   = 1'b1;
          GRP_LATA:  cmd.lat_a_wr = 1'b1;
          GRP_LATB:  cmd.lat_b_wr = 1'b1;
          default:   cmd.sel_wr   = 1'b0;
        endcase
      end
    end
  end

  // Odd locations read back all ones
  always_comb begin
    if (acc_addr[0]) rd_data = {DATA_W{1'b1}};
    else             rd_data = shift_in;
  end

endmodule

// File: rtl/dsd_motor.sv
module dsd_motor #(
  parameter int OFF_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic off_req,
  input  logic on_req,
  output logic motor_en
);

  localparam int CNT_W = $clog2(OFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OFF_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             mot_q, mot_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    mot_d  = mot_q;
    if (on_req) begin
      mot_d  = 1'b1;
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (off_req) begin
      pend_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (pend_q) begin
      if (cnt_q == CNT_LAST) begin
        mot_d  = 1'b0;
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q - CNT_LAST;
      end
    end
  end

  assign upd_en = on_req | off_req | pend_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      mot_q  <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      mot_q  <= mot_d;
    end
  end

  assign motor_en = mot_q;

endmodule

// File: rtl/dsd_drive.sv
module dsd_drive
  import dsd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  sel_wr,
  input  logic                  sel_val,
  input  logic                  motor_en,
  output logic                  drive_sel,
  output logic [NUM_DRIVES-1:0] drive_motor
);

  logic sel_q, sel_d, sel_en;

  // A write of the active drive leaves the register untouched
  assign sel_en = sel_wr & (sel_val != sel_q);

  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = sel_val;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign drive_sel = sel_q;

  for (genvar gi = 0; gi < NUM_DRIVES; gi++) begin : g_drv
    assign drive_motor[gi] = motor_en & (sel_q == gi[0]);
  end

endmodule

// File: rtl/dsd_mode.sv
module dsd_mode (
  input  logic clk,
  input  logic rst_ni,
  input  logic lat_a_wr,
  input  logic lat_b_wr,
  input  logic bit_val,
  input  logic clr_req,
  output logic q6,
  output logic q7,
  output logic sr_clear,
  output logic write_begin,
  output logic write_end
);

  logic q6_q, q6_d, q7_q, q7_d;
  logic clr_q, beg_q, end_q;
  logic beg_d, end_d;
  logic lat_en;

  always_comb begin
    q6_d  = q6_q;
    q7_d  = q7_q;
    beg_d = 1'b0;
    end_d = 1'b0;
    if (lat_a_wr) q6_d = bit_val;
    if (lat_b_wr) begin
      q7_d  = bit_val;
      beg_d = bit_val & ~q7_q;
      end_d = ~bit_val & q7_q;
    end
  end

  assign lat_en = lat_a_wr | lat_b_wr;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q6_q <= 1'b1;
      q7_q <= 1'b0;
    end else if (lat_en) begin
      q6_q <= q6_d;
      q7_q <= q7_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      beg_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      clr_q <= clr_req;
      beg_q <= beg_d;
      end_q <= end_d;
    end
  end

  assign q6          = q6_q;
  assign q7          = q7_q;
  assign sr_clear    = clr_q;
  assign write_begin = beg_q;
  assign write_end   = end_q;

endmodule

// File: rtl/disk_switch_decoder.sv
module disk_switch_decoder
  import dsd_pkg::*;
#(
  parameter int CLK_HZ = 2_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [DATA_W-1:0]     shift_in,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_PHASES-1:0] phase,
  output logic                  motor_en,
  output logic [NUM_DRIVES-1:0] drive_motor,
  output logic                  drive_sel,
  output logic                  q6,
  output logic                  q7,
  output logic                  sr_clear,
  output logic                  write_begin,
  output logic                  write_end
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_ni = rst_sync_q[1];

  dsd_cmd_t cmd;

  dsd_decode u_dec (
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .shift_in  (shift_in),
    .cmd       (cmd),
    .rd_data   (rd_data)
  );

  // Stepper phase lines, one enabled flop each
  logic [NUM_PHASES-1:0] ph_q, ph_d, ph_en;

  for (genvar gp = 0; gp < NUM_PHASES; gp++) begin : g_ph
    assign ph_en[gp] = cmd.phase_wr & (cmd.phase_idx == gp[1:0]);
    assign ph_d[gp]  = cmd.bit_val;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)        ph_q[gp] <= 1'b0;
      else if (ph_en[gp]) ph_q[gp] <= ph_d[gp];
    end
  end

  assign phase = ph_q;

  dsd_motor #(.OFF_CYCLES(CLK_HZ)) u_mot (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .off_req  (cmd.motor_off),
    .on_req   (cmd.motor_on),
    .motor_en (motor_en)
  );

  dsd_drive u_drv (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .sel_wr      (cmd.sel_wr),
    .sel_val     (cmd.bit_val),
    .motor_en    (motor_en),
    .drive_sel   (drive_sel),
    .drive_motor (drive_motor)
  );

  dsd_mode u_mode (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .lat_a_wr    (cmd.lat_a_wr),
    .lat_b_wr    (cmd.lat_b_wr),
    .bit_val     (cmd.bit_val),
    .clr_req     (cmd.motor_off),
    .q6          (q6),
    .q7          (q7),
    .sr_clear    (sr_clear),
    .write_begin (write_begin),
    .write_end   (write_end)
  );

endmodule

// File: rtl/dsd_chk.sv
module dsd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic [3:0] acc_addr,
  input logic [7:0] shift_in,
  input logic [7:0] rd_data,
  input logic [3:0] phase,
  input logic       motor_en,
  input logic [1:0] drive_motor,
  input logic       drive_sel,
  input logic       q6,
  input logic       q7,
  input logic       sr_clear,
  input logic       write_begin,
  input logic       write_end
);

  // R2
  phase_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_addr[3]) |=> (phase[$past(acc_addr[2:1])] == $past(acc_addr[0])));

  // R3
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == 4'h8) |=> sr_clear);

  // R4
  motor_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == 4'h9) |=> motor_en);

  // R6
  drive_motor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_motor) && ((|drive_motor) == motor_en));

  // R7
  reselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[3:1] == 3'b101 && acc_addr[0] == drive_sel) |=> $stable(drive_sel));

  // R9
  begin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_begin |-> (q7 && !$past(q7)));

  // R9
  end_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_end |-> (!q7 && $past(q7)));

  // R10
  odd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr[0] |-> (rd_data == 8'hFF));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(phase) && $stable(q6) && $stable(q7) && $stable(drive_sel)
                    && !sr_clear && !write_begin && !write_end));

endmodule

bind disk_switch_decoder dsd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .shift_in    (shift_in),
  .rd_data     (rd_data),
  .phase       (phase),
  .motor_en    (motor_en),
  .drive_motor (drive_motor),
  .drive_sel   (drive_sel),
  .q6          (q6),
  .q7          (q7),
  .sr_clear    (sr_clear),
  .write_begin (write_begin),
  .write_end   (write_end)
);

// File: tb/tb_disk_switch_decoder.sv
module tb_disk_switch_decoder;

  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_addr = 4'h0;
  logic [7:0] shift_in = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] phase;
  logic       motor_en, drive_sel, q6, q7, sr_clear, write_begin, write_end;
  logic [1:0] drive_motor;

  always #2.5 clk = ~clk;

  disk_switch_decoder #(.CLK_HZ(N)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .shift_in(shift_in), .rd_data(rd_data), .phase(phase), .motor_en(motor_en),
    .drive_motor(drive_motor), .drive_sel(drive_sel), .q6(q6), .q7(q7),
    .sr_clear(sr_clear), .write_begin(write_begin), .write_end(write_end)
  );

  typedef struct {
    logic [20:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state derived from the requirements
  logic [3:0] m_ph;
  logic m_mot, m_pend, m_sel, m_q6, m_q7, m_clr, m_wb, m_we;
  int   m_cnt;

  function automatic logic [20:0] actual();
    return {phase, drive_motor, motor_en, drive_sel, q6, q7,
            sr_clear, write_begin, write_end, rd_data};
  endfunction

  // Monitor: samples 2 ns after each falling edge
  always @(negedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      logic [20:0] act;
      it  = sb.pop_front();
      act = actual();
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input logic v, input logic [3:0] a, input logic [7:0] sh,
                      input string tag);
    item_t it;
    logic [1:0] dm;
    @(negedge clk);
    acc_valid = v;
    acc_addr  = a;
    shift_in  = sh;
    dm = m_mot ? (m_sel ? 2'b10 : 2'b01) : 2'b00;
    it.exp = {m_ph, dm, m_mot, m_sel, m_q6, m_q7, m_clr, m_wb, m_we,
              (a[0] ? 8'hFF : sh)};
    it.tag = tag;
    sb.push_back(it);
    // effect of the coming rising edge
    m_clr = 1'b0; m_wb = 1'b0; m_we = 1'b0;
    if (v && a == 4'h9) begin
      m_mot = 1'b1; m_pend = 1'b0;
    end else if (v && a == 4'h8) begin
      m_clr = 1'b1; m_pend = 1'b1; m_cnt = N;
    end else if (m_pend) begin
      if (m_cnt == 1) begin m_mot = 1'b0; m_pend = 1'b0; end
      else m_cnt--;
    end
    if (v) begin
      if (!a[3]) m_ph[a[2:1]] = a[0];
      else if (a[2:1] == 2'b01) m_sel = a[0];
      else if (a[2:1] == 2'b10) m_q6 = a[0];
      else if (a[2:1] == 2'b11) begin
        if (a[0] && !m_q7) m_wb = 1'b1;
        if (!a[0] && m_q7) m_we = 1'b1;
        m_q7 = a[0];
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'h8, 8'h3C, tag);
  endtask

  initial begin
    m_ph = 4'h0; m_mot = 0; m_pend = 0; m_cnt = 0; m_sel = 0;
    m_q6 = 1; m_q7 = 0; m_clr = 0; m_wb = 0; m_we = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4, "R1");
    // R2 phase set/clear
    step(1, 4'h1, 8'h11, "R2"); step(1, 4'h5, 8'h22, "R2");
    step(1, 4'h7, 8'h33, "R2"); step(1, 4'h3, 8'h44, "R2");
    step(1, 4'h0, 8'h55, "R2"); step(1, 4'h6, 8'hA5, "R2");
    step(1, 4'h2, 8'h5A, "R2"); step(1, 4'h4, 8'h00, "R2");
    // R10 read data patterns
    step(0, 4'h0, 8'h96, "R10"); step(0, 4'hD, 8'h96, "R10");
    step(0, 4'hA, 8'h01, "R10"); step(0, 4'hF, 8'h80, "R10");
    // R8 / R9 latches and write strobes
    step(1, 4'hC, 8'h00, "R8"); step(1, 4'hD, 8'h00, "R8");
    step(1, 4'hF, 8'h00, "R9"); step(1, 4'hF, 8'h00, "R9");
    step(1, 4'hE, 8'h00, "R9"); step(1, 4'hE, 8'h00, "R9");
    step(1, 4'hC, 8'h00, "R8"); idle(2, "R9");
    // R6 / R7 drive selection
    step(1, 4'h9, 8'h00, "R6"); step(1, 4'hB, 8'h00, "R6");
    step(1, 4'hB, 8'h00, "R7"); step(1, 4'hA, 8'h00, "R6");
    step(1, 4'hA, 8'h00, "R7"); idle(2, "R7");
    // R3 delayed shut-off
    step(1, 4'h8, 8'hC3, "R3"); idle(N + 3, "R3");
    // R4 cancel
    step(1, 4'h9, 8'h00, "R4"); step(1, 4'h8, 8'h00, "R4");
    idle(10, "R4"); step(1, 4'h9, 8'h00, "R4"); idle(N + 5, "R4");
    // R5 restart
    step(1, 4'h8, 8'h00, "R5"); idle(20, "R5");
    step(1, 4'h8, 8'h00, "R5"); idle(30, "R5"); idle(15, "R5");
    // R11 strobe low ignores every address
    step(1, 4'h9, 8'h00, "R11");
    for (int k = 0; k < 16; k++) step(0, 4'(k), 8'(k * 17), "R11");
    idle(2, "R11");
    @(negedge clk); #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule